// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the only path into a 16-bit accumulator and its companion one-bit link register (E). Each cycle it takes a data operand, an 8-bit input character and a one-hot operation select. It either updates the accumulator and link together or leaves both as they are. The operations are bitwise AND, addition with the carry-out into the link, load from the data operand, load of the low byte from the input character, clear and complement of the accumulator, clear and complement of the link, increment, and rotation right or left by one place through the link. The rotation covers the 17 bits formed by the link and the accumulator.

The block also drives four condition flags from the registered state. A control sequencer uses them to decide conditional skips: accumulator positive, accumulator negative, accumulator zero and link zero. The block holds no bus, memory or sequencing logic. A sequencer raises one select bit for one cycle, and the result is visible on the outputs after that clock edge.

Top module: `acc_logic_unit`

## Requirements
- R1: After reset, acc_o is 0 and e_o is 0.
- R2: op_sel_i[0] (AND) sets the accumulator to acc_o AND data_i. The link is unchanged.
- R3: op_sel_i[1] (ADD) sets the 17-bit value {e_o, acc_o} to acc_o + data_i. The carry-out replaces the old link value, including when the carry is 0.
- R4: op_sel_i[2] (load data) sets the accumulator to data_i. The link is unchanged.
- R5: op_sel_i[3] (load character) sets acc_o[7:0] to char_i. acc_o[15:8] and the link are unchanged.
- R6: op_sel_i[4] clears the accumulator and op_sel_i[6] complements it. Neither changes the link.
- R7: op_sel_i[5] clears the link and op_sel_i[7] complements it. Neither changes the accumulator.
- R8: op_sel_i[8] (rotate right) shifts the accumulator right by one. The old link value goes into acc_o[15] and the old acc_o[0] goes into the link.
- R9: op_sel_i[9] (rotate left) shifts the accumulator left by one. The old link value goes into acc_o[0] and the old acc_o[15] goes into the link.
- R10: op_sel_i[10] (increment) adds 1 to the accumulator modulo 2^16, so 0xFFFF becomes 0. The link is unchanged.
- R11: When no bit of op_sel_i is set, acc_o and e_o hold their values whatever data_i and char_i carry.
- R12: The flags are registered-state functions:
  - pos_o is 1 exactly when acc_o[15] is 0.
  - neg_o is 1 exactly when acc_o[15] is 1.
  - zero_o is 1 exactly when acc_o is 0.
  - ezero_o is 1 exactly when e_o is 0.
- R13: At most one bit of op_sel_i is set in any cycle. Each operation is requested by its single bit alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Data operand |
| char_i | input | 8 | Input character |
| op_sel_i | input | 11 | One-hot operation select |
| acc_o | output | 16 | Accumulator |
| e_o | output | 1 | Link bit |
| pos_o | output | 1 | Accumulator sign bit is 0 |
| neg_o | output | 1 | Accumulator sign bit is 1 |
| zero_o | output | 1 | Accumulator is zero |
| ezero_o | output | 1 | Link is zero |

## Verification
The assertions check the following on every cycle:
- the select vector carries at most one set bit;
- both rotations move bits between the link and the two ends of the accumulator;
- increment wraps and leaves the link alone;
- loading the character leaves the upper byte alone;
- an idle select holds both registers;
- the positive and negative flags are always opposite.

The bench scenarios show the exact data results: AND and add values, carry-out of both polarities replacing the link, complements and clears, rotations that cross the word end, and the zero flags going high on results of zero.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned SEL_COUNT = 11;
  localparam int unsigned SEL_AND   = 0;
  localparam int unsigned SEL_ADD   = 1;
  localparam int unsigned SEL_LDDR  = 2;
  localparam int unsigned SEL_LDCH  = 3;
  localparam int unsigned SEL_CLRA  = 4;
  localparam int unsigned SEL_CLRE  = 5;
  localparam int unsigned SEL_CPLA  = 6;
  localparam int unsigned SEL_CPLE  = 7;
  localparam int unsigned SEL_ROR   = 8;
  localparam int unsigned SEL_ROL   = 9;
  localparam int unsigned SEL_INC   = 10;
endpackage

// File: rtl/acc_next_logic.sv
module acc_next_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 8
) (
  input  logic [W-1:0]         acc,
  input  logic                 e,
  input  logic [W-1:0]         dr,
  input  logic [CW-1:0]        ch,
  input  logic [SEL_COUNT-1:0] sel,
  output logic [W-1:0]         acc_nxt,
  output logic                 e_nxt
);
  localparam int unsigned WE = W + 1;

  function automatic logic [WE-1:0] f_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [WE-1:0] f_ror(input logic lnk, input logic [W-1:0] a);
    return {a[0], lnk, a[W-1:1]};
  endfunction

  function automatic logic [WE-1:0] f_rol(input logic lnk, input logic [W-1:0] a);
    return {a[W-1], a[W-2:0], lnk};
  endfunction

  logic [WE-1:0] sum_w;
  logic [WE-1:0] ror_w;
  logic [WE-1:0] rol_w;

  assign sum_w = f_add(acc, dr);
  assign ror_w = f_ror(e, acc);
  assign rol_w = f_rol(e, acc);

  always_comb begin
    acc_nxt = acc;
    e_nxt   = e;
    if (sel[SEL_AND])  acc_nxt = acc & dr;
    if (sel[SEL_ADD])  {e_nxt, acc_nxt} = sum_w;
    if (sel[SEL_LDDR]) acc_nxt = dr;
    if (sel[SEL_LDCH]) acc_nxt = {acc[W-1:CW], ch};
    if (sel[SEL_CLRA]) acc_nxt = '0;
    if (sel[SEL_CLRE]) e_nxt = 1'b0;
    if (sel[SEL_CPLA]) acc_nxt = ~acc;
    if (sel[SEL_CPLE]) e_nxt = ~e;
    if (sel[SEL_ROR])  {e_nxt, acc_nxt} = ror_w;
    if (sel[SEL_ROL])  {e_nxt, acc_nxt} = rol_w;
    if (sel[SEL_INC])  acc_nxt = acc + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/acc_flag_logic.sv
module acc_flag_logic #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] acc,
  input  logic         e,
  output logic         pos,
  output logic         neg,
  output logic         zero,
  output logic         ezero
);
  assign neg   = acc[W-1];
  assign pos   = ~acc[W-1];
  assign zero  = (acc == '0);
  assign ezero = ~e;

  // R12: the sign flags never agree
  a_r12_sign_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    pos != neg);
  // R12: a zero accumulator cannot be negative
  a_r12_zero_not_neg: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> pos);
endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
  import acc_alu_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         data_i,
  input  logic [CW-1:0]        char_i,
  input  logic [SEL_COUNT-1:0] op_sel_i,
  output logic [W-1:0]         acc_o,
  output logic                 e_o,
  output logic                 pos_o,
  output logic                 neg_o,
  output logic                 zero_o,
  output logic                 ezero_o
);
  logic [W-1:0] acc_q;
  logic         e_q;
  logic [W-1:0] acc_d;
  logic         e_d;
  logic         op_active;

  assign op_active = |op_sel_i;

  acc_next_logic #(.W(W), .CW(CW)) next_i (
    .acc(acc_q), .e(e_q), .dr(data_i), .ch(char_i), .sel(op_sel_i),
    .acc_nxt(acc_d), .e_nxt(e_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      e_q   <= 1'b0;
    end else if (op_active) begin
      acc_q <= acc_d;
      e_q   <= e_d;
    end
  end

  assign acc_o = acc_q;
  assign e_o   = e_q;

  acc_flag_logic #(.W(W)) flags_i (
    .clk(clk), .rst_n(rst_n), .acc(acc_q), .e(e_q),
    .pos(pos_o), .neg(neg_o), .zero(zero_o), .ezero(ezero_o)
  );

  a_r13_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_sel_i));

  a_r8_ror_ends: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel_i[SEL_ROR] |=> (acc_o[W-1] == $past(e_o)) && (e_o == $past(acc_o[0])));

  a_r9_rol_ends: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel_i[SEL_ROL] |=> (acc_o[0] == $past(e_o)) && (e_o == $past(acc_o[W-1])));

  a_r10_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel_i[SEL_INC] |=> $stable(e_o) && (acc_o == W'($past(acc_o) + 1'b1)));

  a_r5_char_upper: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel_i[SEL_LDCH] |=> $stable(acc_o[W-1:CW]) && $stable(e_o));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_active |=> $stable(acc_o) && $stable(e_o));
endmodule

// File: tb/acc_logic_unit_tb_top.sv
module acc_logic_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] data_i = '0;
  logic [7:0]  char_i = '0;
  logic [10:0] op_sel_i = '0;
  logic [15:0] acc_o;
  logic        e_o, pos_o, neg_o, zero_o, ezero_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_ac = '0;
  logic        m_e = 1'b0;

  always #4 clk = ~clk;

  acc_logic_unit dut_i (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .char_i(char_i), .op_sel_i(op_sel_i),
    .acc_o(acc_o), .e_o(e_o), .pos_o(pos_o), .neg_o(neg_o), .zero_o(zero_o), .ezero_o(ezero_o)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check({tag, " acc"}, acc_o, m_ac);
    check({tag, " link"}, {15'd0, e_o}, {15'd0, m_e});
    check("R12 flags", {12'd0, pos_o, neg_o, zero_o, ezero_o},
          {12'd0, (m_ac < 16'h8000), (m_ac >= 16'h8000), (m_ac == 16'd0), (m_e == 1'b0)});
  endtask

  task automatic apply(input int idx, input logic [15:0] d, input logic [7:0] c);
    @(negedge clk);
    op_sel_i = 11'd1 << idx;
    data_i = d;
    char_i = c;
    @(negedge clk);
    op_sel_i = '0;
  endtask

  task automatic t_reset();
    m_ac = 16'h0000; m_e = 1'b0;
    check_state("R1 reset");
  endtask

  task automatic t_load();
    apply(2, 16'h8001, 8'h00);
    m_ac = 16'h8001;
    check_state("R4 load data");
  endtask

  task automatic t_add();
    apply(1, 16'h8000, 8'h00);
    m_ac = 16'h0001; m_e = 1'b1;
    check_state("R3 add carry one");
    apply(1, 16'h0002, 8'h00);
    m_ac = 16'h0003; m_e = 1'b0;
    check_state("R3 add carry zero");
  endtask

  task automatic t_and();
    apply(7, 16'h0000, 8'h00);
    m_e = 1'b1;
    check_state("R7 link complement");
    apply(2, 16'hF0F0, 8'h00);
    apply(0, 16'h3C3C, 8'h00);
    m_ac = 16'h3030;
    check_state("R2 and");
  endtask

  task automatic t_char();
    apply(2, 16'hABCD, 8'h00);
    apply(3, 16'h1111, 8'h5A);
    m_ac = 16'hAB5A;
    check_state("R5 load char");
  endtask

  task automatic t_acc_ops();
    apply(6, 16'h0000, 8'h00);
    m_ac = 16'h54A5;
    check_state("R6 complement acc");
    apply(4, 16'hFFFF, 8'h00);
    m_ac = 16'h0000;
    check_state("R6 clear acc");
  endtask

  task automatic t_link_ops();
    apply(2, 16'h1234, 8'h00);
    apply(5, 16'h0000, 8'h00);
    m_ac = 16'h1234; m_e = 1'b0;
    check_state("R7 link clear");
  endtask

  task automatic t_rotate();
    apply(2, 16'h0001, 8'h00);
    apply(8, 16'h0000, 8'h00);
    m_ac = 16'h0000; m_e = 1'b1;
    check_state("R8 ror out of bit0");
    apply(8, 16'h0000, 8'h00);
    m_ac = 16'h8000; m_e = 1'b0;
    check_state("R8 ror into bit15");
    apply(9, 16'h0000, 8'h00);
    m_ac = 16'h0000; m_e = 1'b1;
    check_state("R9 rol out of bit15");
    apply(9, 16'h0000, 8'h00);
    m_ac = 16'h0001; m_e = 1'b0;
    check_state("R9 rol into bit0");
  endtask

  task automatic t_inc();
    apply(7, 16'h0000, 8'h00);
    apply(2, 16'hFFFF, 8'h00);
    apply(10, 16'h0000, 8'h00);
    m_ac = 16'h0000; m_e = 1'b1;
    check_state("R10 inc wrap");
    apply(10, 16'h0000, 8'h00);
    m_ac = 16'h0001;
    check_state("R10 inc");
  endtask

  task automatic t_idle();
    @(negedge clk);
    data_i = 16'hDEAD;
    char_i = 8'hBE;
    op_sel_i = '0;
    @(negedge clk);
    @(negedge clk);
    check_state("R11 R13 idle select holds");
  endtask

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_add();
    t_and();
    t_char();
    t_acc_ops();
    t_link_ops();
    t_rotate();
    t_inc();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule